// File: doc/BRIEF.md
# Counter-Flow Pipeline Flush Controller

This block steers recovery in an in-order pipeline of `STAGES` slots when a stage reports a late-arriving (timing) error, without stalling the whole pipeline for a cycle. Each slot carries a valid bit and an instruction sequence tag. Slot 0 is the fetch slot. Slot `STAGES-1` is a stabilization stage that sits in front of storage and cannot report errors. A slot that is valid in the last stage is the value that gets committed.

When a critical stage reports an error, three things happen. The slot just downstream of that stage receives a bubble in the same cycle. The failing stage keeps its instruction for one cycle, so that the corrected value re-enters and moves on without re-execution. A flush token carrying the failing stage number then starts to travel toward fetch at one stage per cycle. At every stop it nullifies its own stage and the stage just upstream. New fetch is held off while the token is in flight. When the token reaches slot 0, a restart request asks fetch to resume at the instruction after the errant one.

If several stages fail together, the one nearest write-back wins. A later error can replace a token that is already in flight, but only if it comes from a stage further downstream than the token's current position.

Top module: `ctflush_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, every slot is invalid, no token is in flight, `fetch_en_o` is 1 and `restart_o` is 0.
- R2: With no accepted error, each slot takes the valid bit and tag of the slot upstream on every clock, unless that upstream slot is nullified in that cycle. Slot 0 loads `fetch_valid_i` and `fetch_tag_i`, and counts the load as valid only when `fetch_en_o` is 1.
- R3: When an error from stage e is accepted, `bubble_o` bit e+1 is 1 in that same cycle, and slot e+1 is invalid on the next cycle.
- R4: The accepted failing stage e shows bit e of `hold_o` and keeps its valid tag for one cycle. In later cycles that tag continues downstream and is not fetched again.
- R5: The cycle after stage e is accepted, the token is valid with position e-1 and identifier e. With no new acceptance, the position then drops by one per cycle and the identifier stays the same.
- R6: `kill_o` marks the slots whose contents are discarded in the current cycle. These are the token's position p and position p-1 (when p-1 exists), plus slot e-1 in the cycle stage e is accepted.
- R7: `restart_o` is 1 exactly in the cycle the token sits at position 0. In that cycle `restart_tag_o` equals the errant tag plus one (modulo 2^TAG_W), and the token is gone in the next cycle unless a new error is accepted.
- R8: `fetch_en_o` is 0 in every cycle a token is in flight, and slot 0 is invalid in the following cycle.
- R9: If several eligible stages report errors in one cycle, only the highest-numbered one (nearest write-back) is accepted.
- R10: During a flush, an error is accepted only from a stage numbered strictly above the token's current position, and it replaces the token. Errors from other stages leave the token unchanged and `hold_o` at zero.
- R11: Errors from stage 0, from stage STAGES-1, or from a stage whose slot is invalid are ignored: `hold_o` and `bubble_o` stay zero and no token starts.
- R12: The tags that leave the last stage as valid appear in strict program order. Each one is the previous one plus one (modulo 2^TAG_W), so no younger or flushed instruction reaches storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | Fetch offers an instruction this cycle |
| fetch_tag_i | input | TAG_W | Sequence tag of the offered instruction |
| stage_err_i | input | STAGES | Per-stage timing-error flags, bit i for stage i |
| fetch_en_o | output | 1 | Fetch is allowed to load slot 0 |
| slot_valid_o | output | STAGES | Valid bit of each slot |
| slot_tag_o | output | STAGES*TAG_W | Tag of each slot, slot i in bits [i*TAG_W +: TAG_W] |
| bubble_o | output | STAGES | Slot that receives a bubble this cycle |
| hold_o | output | STAGES | One-hot accepted failing stage this cycle |
| kill_o | output | STAGES | Slots whose contents are discarded this cycle |
| train_valid_o | output | 1 | A flush token is in flight |
| train_pos_o | output | ID_W | Stage the token currently occupies |
| train_id_o | output | ID_W | Identifier of the stage that launched the token |
| restart_o | output | 1 | Fetch must resume at restart_tag_o next cycle |
| restart_tag_o | output | TAG_W | Tag of the instruction after the errant one |

## Verification
The bench builds the block with STAGES=6 and TAG_W=8. Six stages give four error-capable stages, which is enough for simultaneous errors in non-adjacent stages, a replacement arriving from a stage ahead of a token already two hops into its trip, and an ignored error behind the token. The 8-bit tag wraps during the long pseudo-random phase, which exercises the modulo step in the restart tag and in the commit-order check.

// File: rtl/ctf_pkg.sv
package ctf_pkg;

    // Per-slot update choice made by the controller each cycle
    typedef enum logic [1:0] {
        SLOT_SHIFT  = 2'd0,
        SLOT_HOLD   = 2'd1,
        SLOT_BUBBLE = 2'd2,
        SLOT_LOAD   = 2'd3
    } slot_op_e;

    // Stages that may raise a timing error: not fetch, not the stabilization stage
    function automatic logic is_critical(input int idx, input int n_stages);
        return (idx >= 1) && (idx <= n_stages - 2);
    endfunction

endpackage

// File: rtl/ctf_slot_pipe.sv
module ctf_slot_pipe
    import ctf_pkg::*;
#(
    parameter int STAGES = 6,
    parameter int TAG_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  slot_op_e                 op [STAGES],
    input  logic [STAGES-1:0]        kill,
    input  logic                     load_valid,
    input  logic [TAG_W-1:0]         load_tag,
    output logic [STAGES-1:0]        valid_q,
    output logic [STAGES*TAG_W-1:0]  tag_q
);

    for (genvar i = 0; i < STAGES; i++) begin : g_slot
        logic             v_src;
        logic [TAG_W-1:0] t_src;
        logic             v_r;
        logic [TAG_W-1:0] t_r;

        if (i == 0) begin : g_head
            assign v_src = load_valid;
            assign t_src = load_tag;
        end else begin : g_body
            assign v_src = valid_q[i-1] & ~kill[i-1];
            assign t_src = tag_q[(i-1)*TAG_W +: TAG_W];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                v_r <= 1'b0;
                t_r <= '0;
            end else if (op[i] == SLOT_BUBBLE) begin
                v_r <= 1'b0;
            end else if (op[i] != SLOT_HOLD) begin
                v_r <= v_src;
                t_r <= t_src;
            end
        end

        assign valid_q[i]              = v_r;
        assign tag_q[i*TAG_W +: TAG_W] = t_r;
    end

endmodule

// File: rtl/ctf_err_arb.sv
module ctf_err_arb
    import ctf_pkg::*;
#(
    parameter int STAGES = 6,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] err,
    input  logic [STAGES-1:0] slot_valid,
    input  logic              train_valid,
    input  logic [ID_W-1:0]   train_pos,
    output logic              launch,
    output logic [ID_W-1:0]   launch_idx,
    output logic [STAGES-1:0] hold
);

    logic [STAGES-1:0] elig;

    // A stage may start recovery only if critical, occupied and ahead of any token
    always_comb begin
        elig = '0;
        for (int i = 0; i < STAGES; i++) begin
            if (is_critical(i, STAGES) && err[i] && slot_valid[i] &&
                (!train_valid || (i > int'(train_pos)))) begin
                elig[i] = 1'b1;
            end
        end
    end

    // Ascending scan: the last hit is the one nearest write-back
    always_comb begin
        launch     = 1'b0;
        launch_idx = '0;
        hold       = '0;
        for (int i = 0; i < STAGES; i++) begin
            if (elig[i]) begin
                launch     = 1'b1;
                launch_idx = ID_W'(i);
            end
        end
        if (launch) hold[launch_idx] = 1'b1;
    end

    // R9
    single_winner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hold));

    for (genvar i = 0; i < STAGES; i++) begin : g_prio_chk
        // R9
        nearest_wb_wins_chk: assert property (@(posedge clk) disable iff (rst)
            elig[i] |-> (launch && (int'(launch_idx) >= i)));
    end

    // R10
    replace_ahead_only_chk: assert property (@(posedge clk) disable iff (rst)
        (train_valid && launch) |-> (int'(launch_idx) > int'(train_pos)));

endmodule

// File: rtl/ctf_flush_train.sv
module ctf_flush_train #(
    parameter int STAGES = 6,
    parameter int ID_W   = 3,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [ID_W-1:0]   launch_idx,
    input  logic [TAG_W-1:0]  launch_tag,
    output logic              train_valid,
    output logic [ID_W-1:0]   train_pos,
    output logic [ID_W-1:0]   train_id,
    output logic [STAGES-1:0] kill,
    output logic              restart,
    output logic [TAG_W-1:0]  restart_tag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            train_valid <= 1'b0;
            train_pos   <= '0;
            train_id    <= '0;
            restart_tag <= '0;
        end else if (launch) begin
            train_valid <= 1'b1;
            train_pos   <= launch_idx - 1'b1;
            train_id    <= launch_idx;
            restart_tag <= launch_tag + 1'b1;
        end else if (train_valid) begin
            if (train_pos == '0) train_valid <= 1'b0;
            else                 train_pos   <= train_pos - 1'b1;
        end
    end

    // Two slots per hop: the token's own stage and the one just upstream
    always_comb begin
        for (int j = 0; j < STAGES; j++) begin
            kill[j] = train_valid &&
                      ((int'(train_pos) == j) || (int'(train_pos) == j + 1));
        end
    end

    assign restart = train_valid && (train_pos == '0);

    // R5
    token_walks_chk: assert property (@(posedge clk) disable iff (rst)
        (train_valid && (train_pos != '0) && !launch)
            |=> (train_valid && (train_pos == $past(train_pos) - 1'b1)));

    // R5
    token_id_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (train_valid && !launch) |=> ($stable(train_id) || !train_valid));

endmodule

// File: rtl/ctflush_ctrl.sv
module ctflush_ctrl
    import ctf_pkg::*;
#(
    parameter int  STAGES = 6,
    parameter int  TAG_W  = 8,
    localparam int ID_W   = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fetch_valid_i,
    input  logic [TAG_W-1:0]         fetch_tag_i,
    input  logic [STAGES-1:0]        stage_err_i,
    output logic                     fetch_en_o,
    output logic [STAGES-1:0]        slot_valid_o,
    output logic [STAGES*TAG_W-1:0]  slot_tag_o,
    output logic [STAGES-1:0]        bubble_o,
    output logic [STAGES-1:0]        hold_o,
    output logic [STAGES-1:0]        kill_o,
    output logic                     train_valid_o,
    output logic [ID_W-1:0]          train_pos_o,
    output logic [ID_W-1:0]          train_id_o,
    output logic                     restart_o,
    output logic [TAG_W-1:0]         restart_tag_o
);

    logic              launch;
    logic [ID_W-1:0]   launch_idx;
    logic [TAG_W-1:0]  errant_tag;
    logic [STAGES-1:0] train_kill;
    slot_op_e          op [STAGES];

    ctf_err_arb #(
        .STAGES (STAGES),
        .ID_W   (ID_W)
    ) u_arb (
        .clk         (clk),
        .rst         (rst),
        .err         (stage_err_i),
        .slot_valid  (slot_valid_o),
        .train_valid (train_valid_o),
        .train_pos   (train_pos_o),
        .launch      (launch),
        .launch_idx  (launch_idx),
        .hold        (hold_o)
    );

    assign errant_tag = slot_tag_o[launch_idx*TAG_W +: TAG_W];

    ctf_flush_train #(
        .STAGES (STAGES),
        .ID_W   (ID_W),
        .TAG_W  (TAG_W)
    ) u_train (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_idx  (launch_idx),
        .launch_tag  (errant_tag),
        .train_valid (train_valid_o),
        .train_pos   (train_pos_o),
        .train_id    (train_id_o),
        .kill        (train_kill),
        .restart     (restart_o),
        .restart_tag (restart_tag_o)
    );

    // Fetch is held off for the whole trip of a token
    assign fetch_en_o = !train_valid_o;

    // Launch drops the instruction just upstream of the held stage
    assign kill_o   = train_kill | (hold_o >> 1);
    assign bubble_o = hold_o << 1;

    for (genvar i = 0; i < STAGES; i++) begin : g_op
        if (i == 0) begin : g_fetch
            assign op[i] = hold_o[i] ? SLOT_HOLD : SLOT_LOAD;
        end else begin : g_stage
            assign op[i] = hold_o[i]   ? SLOT_HOLD   :
                           hold_o[i-1] ? SLOT_BUBBLE : SLOT_SHIFT;
        end
    end

    ctf_slot_pipe #(
        .STAGES (STAGES),
        .TAG_W  (TAG_W)
    ) u_slots (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .kill       (kill_o),
        .load_valid (fetch_valid_i & fetch_en_o),
        .load_tag   (fetch_tag_i),
        .valid_q    (slot_valid_o),
        .tag_q      (slot_tag_o)
    );

    // R3
    bubble_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (|bubble_o) |=> ((slot_valid_o & $past(bubble_o)) == '0));

    // R4
    held_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (|hold_o) |=> ((slot_valid_o & $past(hold_o)) == $past(hold_o)));

    // R8
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        train_valid_o |=> !slot_valid_o[0]);

    // R7
    restart_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (restart_o && !(|hold_o)) |=> !train_valid_o);

    // R11
    edge_err_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        ((stage_err_i & ~(stage_err_i[0] ? STAGES'(1) : '0)
                      & ~(stage_err_i[STAGES-1] ? (STAGES'(1) << (STAGES-1)) : '0)) == '0)
            |-> (hold_o == '0));

endmodule

// File: tb/test_ctflush_ctrl.sv
module test_ctflush_ctrl;
    localparam int ST = 6;
    localparam int TW = 8;
    localparam int IW = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             fetch_valid_i;
    logic [TW-1:0]    fetch_tag_i;
    logic [ST-1:0]    stage_err_i;
    logic             fetch_en_o;
    logic [ST-1:0]    slot_valid_o;
    logic [ST*TW-1:0] slot_tag_o;
    logic [ST-1:0]    bubble_o, hold_o, kill_o;
    logic             train_valid_o;
    logic [IW-1:0]    train_pos_o, train_id_o;
    logic             restart_o;
    logic [TW-1:0]    restart_tag_o;

    always #10 clk = ~clk;

    ctflush_ctrl #(.STAGES(ST), .TAG_W(TW)) i_ctflush_ctrl (
        .clk(clk), .rst(rst),
        .fetch_valid_i(fetch_valid_i), .fetch_tag_i(fetch_tag_i),
        .stage_err_i(stage_err_i), .fetch_en_o(fetch_en_o),
        .slot_valid_o(slot_valid_o), .slot_tag_o(slot_tag_o),
        .bubble_o(bubble_o), .hold_o(hold_o), .kill_o(kill_o),
        .train_valid_o(train_valid_o), .train_pos_o(train_pos_o),
        .train_id_o(train_id_o), .restart_o(restart_o),
        .restart_tag_o(restart_tag_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Behavioural reference state
    bit m_v [ST];
    int m_t [ST];
    bit tk_v;
    int tk_p, tk_id, m_rs, nf, last_commit;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < ST; i++) begin m_v[i] = 1'b0; m_t[i] = 0; end
        tk_v = 1'b0; tk_p = 0; tk_id = 0; m_rs = 0; nf = 0; last_commit = -1;
    endtask

    // One clock: drive at the falling edge, compare, then advance the reference
    task automatic step(input logic [ST-1:0] err, input bit gap);
        bit            fen, fv;
        int            win;
        logic [ST-1:0] ekill, ebub, ehold, vexp;
        bit            nv [ST];
        int            nt [ST];
        @(negedge clk);
        fen = !tk_v;
        fv  = fen && !gap;
        stage_err_i   = err;
        fetch_valid_i = !gap;
        fetch_tag_i   = TW'(nf);
        win = -1;
        for (int i = 1; i <= ST - 2; i++)
            if (err[i] && m_v[i] && (!tk_v || i > tk_p)) win = i;
        ekill = '0; ebub = '0; ehold = '0; vexp = '0;
        for (int j = 0; j < ST; j++) begin
            if (tk_v && (j == tk_p || j == tk_p - 1)) ekill[j] = 1'b1;
            if (win >= 0 && j == win - 1) ekill[j] = 1'b1;
            vexp[j] = m_v[j];
        end
        if (win >= 0) begin
            ehold[win] = 1'b1;
            ebub[win+1] = 1'b1;
        end
        #2;
        chk(fetch_en_o == fen, "R8", "fetch_en", fetch_en_o, fen);
        chk(slot_valid_o == vexp, "R2", "slot_valid", slot_valid_o, vexp);
        for (int i = 0; i < ST; i++)
            if (m_v[i])
                chk(slot_tag_o[i*TW +: TW] == TW'(m_t[i]), "R2", "slot_tag",
                    slot_tag_o[i*TW +: TW], m_t[i]);
        chk(bubble_o == ebub, "R3", "bubble", bubble_o, ebub);
        chk(hold_o == ehold, "R4", "hold", hold_o, ehold);
        chk(kill_o == ekill, "R6", "kill", kill_o, ekill);
        chk(train_valid_o == tk_v, "R5", "train_valid", train_valid_o, tk_v);
        if (tk_v) begin
            chk(int'(train_pos_o) == tk_p, "R5", "train_pos", train_pos_o, tk_p);
            chk(int'(train_id_o) == tk_id, "R5", "train_id", train_id_o, tk_id);
        end
        chk(restart_o == (tk_v && tk_p == 0), "R7", "restart", restart_o, tk_v && tk_p == 0);
        if (tk_v && tk_p == 0)
            chk(int'(restart_tag_o) == m_rs, "R7", "restart_tag", restart_tag_o, m_rs);
        if (slot_valid_o[ST-1]) begin
            if (last_commit >= 0)
                chk(int'(slot_tag_o[(ST-1)*TW +: TW]) == ((last_commit + 1) & 255), "R12",
                    "commit_order", slot_tag_o[(ST-1)*TW +: TW], (last_commit + 1) & 255);
            last_commit = int'(slot_tag_o[(ST-1)*TW +: TW]);
        end
        // advance reference
        for (int i = 0; i < ST; i++) begin
            if (win == i) begin
                nv[i] = m_v[i]; nt[i] = m_t[i];
            end else if (win >= 0 && i == win + 1) begin
                nv[i] = 1'b0; nt[i] = m_t[i];
            end else if (i == 0) begin
                nv[i] = fv; nt[i] = nf;
            end else begin
                nv[i] = m_v[i-1] && !ekill[i-1]; nt[i] = m_t[i-1];
            end
        end
        if (fv) nf = (nf + 1) & 255;
        if (tk_v && tk_p == 0) nf = m_rs;
        if (win >= 0) begin
            m_rs = (m_t[win] + 1) & 255;
            tk_v = 1'b1; tk_p = win - 1; tk_id = win;
        end else if (tk_v) begin
            if (tk_p == 0) tk_v = 1'b0;
            else           tk_p = tk_p - 1;
        end
        for (int i = 0; i < ST; i++) begin m_v[i] = nv[i]; m_t[i] = nt[i]; end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step('0, 1'b0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        int tag3;
        rst = 1'b1; fetch_valid_i = 1'b0; fetch_tag_i = '0; stage_err_i = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 state held in reset
        chk(slot_valid_o == '0, "R1", "slot_valid in reset", slot_valid_o, 0);
        chk(train_valid_o == 1'b0, "R1", "train_valid in reset", train_valid_o, 0);
        chk(fetch_en_o == 1'b1, "R1", "fetch_en in reset", fetch_en_o, 1);
        chk(restart_o == 1'b0, "R1", "restart in reset", restart_o, 0);
        rst = 1'b0;

        // R11: error on an empty slot before the pipeline fills
        step(ST'(1) << 3, 1'b0);
        chk(hold_o == '0, "R11", "hold on empty slot", hold_o, 0);
        idle(8);

        // R11: fetch stage and stabilization stage cannot start recovery
        step(ST'(1) | (ST'(1) << (ST-1)), 1'b0);
        chk(hold_o == '0, "R11", "hold on edge stages", hold_o, 0);
        step('0, 1'b0);
        chk(train_valid_o == 1'b0, "R11", "no token from edge stages", train_valid_o, 0);
        idle(4);

        // R3..R7: single error at stage 3, token walks to fetch
        tag3 = m_t[3];
        step(ST'(1) << 3, 1'b0);
        step('0, 1'b0);
        chk(train_id_o == 3'd3 && train_pos_o == 3'd2, "R5", "token after launch",
            train_pos_o, 2);
        step('0, 1'b0);
        step('0, 1'b0);
        chk(restart_o == 1'b1, "R7", "restart at fetch", restart_o, 1);
        chk(int'(restart_tag_o) == ((tag3 + 1) & 255), "R7", "restart tag",
            restart_tag_o, (tag3 + 1) & 255);
        idle(10);

        // R9: stages 2 and 4 fail together
        step((ST'(1) << 2) | (ST'(1) << 4), 1'b0);
        step('0, 1'b0);
        chk(train_id_o == 3'd4, "R9", "winner id", train_id_o, 4);
        idle(10);

        // R10: token from stage 2 replaced by a later error at stage 4
        step(ST'(1) << 2, 1'b0);
        step(ST'(1) << 4, 1'b0);
        chk(hold_o == (ST'(1) << 4), "R10", "replacement accepted", hold_o, 16);
        step('0, 1'b0);
        chk(train_id_o == 3'd4 && train_pos_o == 3'd3, "R10", "replaced token",
            train_id_o, 4);
        idle(10);

        // R10: error behind the token is ignored
        step(ST'(1) << 4, 1'b0);
        step(ST'(1) << 2, 1'b0);
        chk(hold_o == '0, "R10", "upstream error ignored", hold_o, 0);
        step('0, 1'b0);
        chk(train_id_o == 3'd4 && train_pos_o == 3'd2, "R10", "token unchanged",
            train_pos_o, 2);
        idle(10);

        // Mixed traffic: pseudo-random errors and fetch gaps
        for (int k = 0; k < 1500; k++) begin
            logic [ST-1:0] e;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            e = (lfsr[2:0] == 3'd0) ? lfsr[8:3] : '0;
            step(e, lfsr[11:10] == 2'd0);
        end
        idle(10);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end
endmodule